// File: doc/BRIEF.md
# Memory-mapped serial flash read engine

This block lets a host read a serial NOR flash as if it were plain memory. Software first stores a frame template in a memory-command register. The template holds the opcode, the number of address bytes, the number of intermediate (dummy) bytes and the data lane format. Once a valid template is stored, the engine enters memory mode and raises `mem_active`. While `mem_active` is high the engine owns the shared serial pins, and the command sequencer must leave them alone. Every read on the simple memory bus (address, valid, size, ready, read data) then becomes exactly one flash read frame built from the stored template.

Memory mode ends only through an explicit mode-reset pulse. The pulse drops `mem_active` at once and returns the pins to command use. While memory mode is active:
- a write to the command register is refused and latched into a sticky error flag;
- a new template write is ignored.

The controller runs as one state machine with seven states:
- OFF: pins released.
- IDLE: armed, waiting for a bus read.
- OPC: opcode is shifted out.
- ADDR: address bytes are shifted out.
- DUMMY: intermediate clocks run with the outputs disabled.
- DATA: read data is sampled.
- DONE: the one-cycle bus reply.

The transitions are:
- OFF→IDLE when memory mode is active.
- IDLE→OPC when a bus read is valid.
- OPC→ADDR after 8 clocks.
- ADDR→DUMMY after the address clocks, if the dummy count is non-zero; otherwise ADDR→DATA.
- DUMMY→DATA after the dummy clocks.
- DATA→DONE after the data clocks.
- DONE→IDLE.
- Any state goes to OFF on a mode-reset pulse.

Top module: `flash_mmap_reader`

## Requirements
- R1: After reset, `mem_active`, `cmd_err`, `bus_ready` and `sclk` are 0 and `cs_n` is 1. A template write with a valid word while memory mode is off sets `mem_active` on the following clock edge.
- R2: The template word is decoded as follows:
  - opcode in bits [31:24];
  - frame code in bits [23:21], equal to the address byte count plus one;
  - lane format in bits [20:19];
  - intermediate byte count in bits [18:16].
  
  A frame code outside 2..5, or a lane format other than 0 or 1, is refused, and `mem_active` stays 0.
- R3: Each frame sends the 8-bit opcode and then the low address bytes of `bus_addr`, most significant bit first, on `io_out[0]` with `io_oe` = 0001.
  - `sclk` idles low and each serial clock spans two system clocks.
  - `cs_n` is low for the whole frame.
- R4: After the address, the frame runs exactly 8 × (intermediate byte count) serial clocks with `io_oe` = 0000. It runs none when that count is 0.
- R5: Read data is sampled on the rising `sclk` edge, most significant bit of each byte first:
  - Lane format 0 takes 1 bit per clock from `io_in[1]`.
  - Lane format 1 with `lane_quad` = 0 takes 2 bits per clock from `io_in[1:0]`, with `io_in[1]` first.
  - Lane format 1 with `lane_quad` = 1 takes 4 bits per clock from `io_in[3:0]`, with `io_in[3]` first.
- R6: `bus_size` selects the read width: 0 for 1 byte, 1 for 2 bytes, 2 or 3 for 4 bytes.
  - The frame runs bytes × 8 / lanes data clocks.
  - `bus_rdata` is little-endian: the first received byte goes in bits [7:0].
  - Unused upper bytes are zero.
- R7: `bus_ready` is a single-cycle pulse carrying `bus_rdata`. Each accepted read produces exactly one frame, and `cs_n` returns high when `bus_ready` rises.
- R8: A `mode_reset` pulse clears `mem_active` on the next edge. After that, a held bus read starts no frame and gets no `bus_ready`.
- R9: `cmd_wr` while `mem_active` is 1 sets `cmd_err`, which stays set until `rst_n`. `cmd_wr` while memory mode is off leaves `cmd_err` at 0.
- R10: A template write while `mem_active` is 1 is ignored. Later frames keep the previously stored opcode and address length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmpl_wr | input | 1 | Memory-command register write strobe |
| tmpl_wdata | input | 32 | Memory-command word |
| cmd_wr | input | 1 | Command register write strobe (from register bus) |
| mode_reset | input | 1 | Pulse that leaves memory mode |
| lane_quad | input | 1 | Wide lane select: 0 two lanes, 1 four lanes |
| bus_valid | input | 1 | Bus read request, held until `bus_ready` |
| bus_addr | input | ADDR_W | Bus read address |
| bus_size | input | 2 | Read width code |
| bus_ready | output | 1 | Read completion pulse |
| bus_rdata | output | 32 | Read data, little-endian |
| mem_active | output | 1 | Memory mode active (status bit 0) |
| cmd_err | output | 1 | Sticky refused-command flag |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Serial data output enables |
| io_in | input | 4 | Serial data in |

## Verification
The bench sweeps a small grid that covers every combination of:
- address length, 1 to 4 bytes;
- dummy count, 0 to 2 bytes;
- lane mode: serial, dual or quad;
- read width: 1, 2 or 4 bytes.

A behavioural flash model in the bench answers each read with bytes computed from the received address.

- Varying the address length separates address truncation and byte order.
- Varying the dummy count exposes off-by-one clock counts.
- The three lane modes separate lane mapping and bit order within a byte.
- The three widths separate little-endian assembly and zero fill of the upper bytes.

Targeted sequences then cover:
- refused templates;
- the sticky command error;
- a template write that is ignored while memory mode is active;
- a held bus read after a mode reset, which must stay unanswered.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

    // Field positions of the template word (shared with the command word)
    localparam int OPC_LSB = 24;
    localparam int FRM_LSB = 21;
    localparam int FLD_LSB = 19;
    localparam int GAP_LSB = 16;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_IDLE  = 3'd1,
        S_OPC   = 3'd2,
        S_ADDR  = 3'd3,
        S_DUMMY = 3'd4,
        S_DATA  = 3'd5,
        S_DONE  = 3'd6
    } mfr_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] abytes;   // 1..4
        logic [2:0] gap;      // intermediate bytes
        logic       wide;     // data on 2/4 lanes
    } mfr_tmpl_t;

    function automatic logic tmpl_ok(input logic [31:0] w);
        logic [2:0] frm;
        logic [1:0] fld;
        frm = w[FRM_LSB +: 3];
        fld = w[FLD_LSB +: 2];
        return (frm >= 3'd2) && (frm <= 3'd5) && (fld <= 2'd1);
    endfunction

    function automatic mfr_tmpl_t tmpl_decode(input logic [31:0] w);
        mfr_tmpl_t t;
        t.opcode = w[OPC_LSB +: 8];
        t.abytes = w[FRM_LSB +: 3] - 3'd1;
        t.gap    = w[GAP_LSB +: 3];
        t.wide   = w[FLD_LSB];
        return t;
    endfunction

endpackage

// File: rtl/mfr_cfg.sv
module mfr_cfg
    import mfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tmpl_wr,
    input  logic [31:0] tmpl_wdata,
    input  logic        cmd_wr,
    input  logic        mode_reset,
    output mfr_tmpl_t   tmpl,
    output logic        active,
    output logic        cmd_err
);

    logic unused_low;
    assign unused_low = ^{tmpl_wdata[15:0], tmpl_wdata[20]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmpl    <= '0;
            active  <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            if (mode_reset) begin
                active <= 1'b0;
            end else if (tmpl_wr && !active && tmpl_ok(tmpl_wdata)) begin
                active <= 1'b1;
                tmpl   <= tmpl_decode(tmpl_wdata);
            end
            if (cmd_wr && active) begin
                cmd_err <= 1'b1;
            end
        end
    end

    // R1: a valid template arms memory mode on the next edge
    p_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmpl_wr && !active && !mode_reset && tmpl_ok(tmpl_wdata)) |=> active);

    // R2: a refused template leaves memory mode off
    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmpl_wr && !active && !tmpl_ok(tmpl_wdata)) |=> !active);

    // R8: mode reset leaves memory mode
    p_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reset |=> !active);

    // R9: error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R10: template frozen while active
    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !mode_reset) |=> $stable(tmpl));

endmodule

// File: rtl/mfr_gather.sv
module mfr_gather #(
    parameter int DATA_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      sample,
    input  logic [1:0]                lane_sel,   // 0 serial, 1 dual, 2 quad
    input  logic [1:0]                size_sel,   // 0:1B 1:2B else 4B
    input  logic [3:0]                io_in,
    output logic [8*DATA_BYTES-1:0]   rdata
);

    localparam int SH_W = 8 * DATA_BYTES;

    logic [SH_W-1:0] sh;
    logic [SH_W-1:0] rev;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh <= '0;
        end else if (sample) begin
            unique case (lane_sel)
                2'd0:    sh <= {sh[SH_W-2:0], io_in[1]};
                2'd1:    sh <= {sh[SH_W-3:0], io_in[1:0]};
                default: sh <= {sh[SH_W-5:0], io_in};
            endcase
        end
    end

    // Byte reversal: first received byte ends in the lowest lane
    for (genvar k = 0; k < DATA_BYTES; k++) begin : g_rev
        assign rev[8*k +: 8] = sh[8*(DATA_BYTES-1-k) +: 8];
    end

    always_comb begin
        unique case (size_sel)
            2'd0:    rdata = {{(SH_W-8){1'b0}},  sh[7:0]};
            2'd1:    rdata = {{(SH_W-16){1'b0}}, sh[7:0], sh[15:8]};
            default: rdata = rev;
        endcase
    end

endmodule

// File: rtl/flash_mmap_reader.sv
module flash_mmap_reader
    import mfr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmpl_wr,
    input  logic [31:0]       tmpl_wdata,
    input  logic              cmd_wr,
    input  logic              mode_reset,
    input  logic              lane_quad,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              mem_active,
    output logic              cmd_err,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    localparam int CNT_W = 6;
    localparam int TX_W  = 40;

    mfr_state_e       state, nxt;
    mfr_tmpl_t        tmpl;
    logic             ph;
    logic [CNT_W-1:0] cnt;
    logic [TX_W-1:0]  tx;
    logic [1:0]       lane_sel;
    logic [1:0]       size_sel;
    logic [CNT_W-1:0] data_last;
    logic [CNT_W-1:0] addr_last;
    logic [CNT_W-1:0] gap_last;
    logic [31:0]      a32;
    logic [31:0]      gathered;
    logic             accept;
    logic             in_frame;
    logic [1:0]       lane_sel_n;
    logic [CNT_W-1:0] bits_n;

    if (ADDR_W >= 32) begin : g_addr_wide
        assign a32 = bus_addr[31:0];
    end else begin : g_addr_narrow
        assign a32 = {{(32-ADDR_W){1'b0}}, bus_addr};
    end

    mfr_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmpl_wr    (tmpl_wr),
        .tmpl_wdata (tmpl_wdata),
        .cmd_wr     (cmd_wr),
        .mode_reset (mode_reset),
        .tmpl       (tmpl),
        .active     (mem_active),
        .cmd_err    (cmd_err)
    );

    mfr_gather #(.DATA_BYTES(4)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .sample   (state == S_DATA && !ph),
        .lane_sel (lane_sel),
        .size_sel (size_sel),
        .io_in    (io_in),
        .rdata    (gathered)
    );

    assign accept     = (state == S_IDLE) && bus_valid && !mode_reset;
    assign addr_last  = {tmpl.abytes, 3'b000} - 6'd1;
    assign gap_last   = {tmpl.gap, 3'b000} - 6'd1;
    assign lane_sel_n = !tmpl.wide ? 2'd0 : (lane_quad ? 2'd2 : 2'd1);
    assign bits_n     = (bus_size == 2'd0) ? 6'd8 : (bus_size == 2'd1) ? 6'd16 : 6'd32;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   if (mem_active) nxt = S_IDLE;
            S_IDLE:  if (bus_valid) nxt = S_OPC;
            S_OPC:   if (ph && cnt == 6'd7) nxt = S_ADDR;
            S_ADDR:  if (ph && cnt == addr_last) nxt = (tmpl.gap != 3'd0) ? S_DUMMY : S_DATA;
            S_DUMMY: if (ph && cnt == gap_last) nxt = S_DATA;
            S_DATA:  if (ph && cnt == data_last) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_OFF;
        endcase
        if (mode_reset) nxt = S_OFF;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // Frame datapath: phase, clock counter, shift-out register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= 1'b0;
            cnt       <= '0;
            tx        <= '0;
            lane_sel  <= 2'd0;
            size_sel  <= 2'd0;
            data_last <= '0;
        end else if (accept) begin
            ph        <= 1'b0;
            cnt       <= '0;
            tx        <= {tmpl.opcode, a32 << {3'd4 - tmpl.abytes, 3'b000}};
            lane_sel  <= lane_sel_n;
            size_sel  <= bus_size;
            data_last <= (bits_n >> lane_sel_n) - 6'd1;
        end else if (in_frame) begin
            ph <= ~ph;
            if (ph) begin
                cnt <= (nxt != state) ? '0 : cnt + 6'd1;
                if (state == S_OPC || state == S_ADDR) begin
                    tx <= {tx[TX_W-2:0], 1'b0};
                end
            end
        end else begin
            ph  <= 1'b0;
            cnt <= '0;
        end
    end

    // Outputs
    always_comb begin
        in_frame  = (state == S_OPC) || (state == S_ADDR) ||
                    (state == S_DUMMY) || (state == S_DATA);
        cs_n      = !in_frame;
        sclk      = in_frame && ph;
        io_out    = {3'b000, tx[TX_W-1]};
        io_oe     = (state == S_OPC || state == S_ADDR) ? 4'b0001 : 4'b0000;
        bus_ready = (state == S_DONE);
        bus_rdata = bus_ready ? gathered : 32'h0;
    end

    // R8: with memory mode off the pins stay idle and no reply appears
    p_idle_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_active |-> (cs_n && !bus_ready));

    // R7: reply is a one-cycle pulse
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R7: a frame ends only with a reply or a mode reset
    p_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (bus_ready || !mem_active));

    // R3: clock low and outputs off between frames
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && io_oe == 4'b0000));

    // R3: at most one output lane driven
    p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(io_oe));

endmodule

// File: tb/flash_mmap_reader_bench.sv
module flash_mmap_reader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmpl_wr = 1'b0;
    logic [31:0] tmpl_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic        mode_reset = 1'b0;
    logic        lane_quad = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        mem_active;
    logic        cmd_err;
    logic        sclk;
    logic        cs_n;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;
    logic [3:0]  io_in = '0;

    int checks = 0;
    int errors = 0;

    // flash model configuration (set by the bench from the requirements)
    int m_ab = 1, m_gap = 0, m_lanes = 1, m_nb = 1;
    logic [7:0]  m_op;
    logic [31:0] m_addr;
    bit          m_dummy_oe;
    int          clk_cnt = 0;

    always #10 clk = ~clk;

    flash_mmap_reader #(.ADDR_W(32)) u_flash_mmap_reader (
        .clk(clk), .rst_n(rst_n), .tmpl_wr(tmpl_wr), .tmpl_wdata(tmpl_wdata),
        .cmd_wr(cmd_wr), .mode_reset(mode_reset), .lane_quad(lane_quad),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .mem_active(mem_active),
        .cmd_err(cmd_err), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [7:0] fbyte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] op, input logic [2:0] frm,
                                       input logic [1:0] fld, input logic [2:0] gap);
        return {op, frm, fld, gap, 16'h0000};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // serial clock counter for each frame
    always @(negedge cs_n) clk_cnt = 0;
    always @(posedge sclk) clk_cnt++;

    // behavioural flash
    initial begin
        forever begin
            @(negedge cs_n);
            m_op = '0; m_addr = '0; m_dummy_oe = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(posedge sclk); m_op = {m_op[6:0], io_out[0]};
            end
            for (int i = 0; i < m_ab * 8; i++) begin
                @(posedge sclk); m_addr = {m_addr[30:0], io_out[0]};
            end
            for (int i = 0; i < m_gap * 8; i++) begin
                @(posedge sclk); if (io_oe != 4'b0000) m_dummy_oe = 1'b1;
            end
            for (int c = 0; c < (m_nb * 8) / m_lanes; c++) begin
                logic [3:0] v;
                @(negedge sclk);
                v = '0;
                for (int j = 0; j < m_lanes; j++) begin
                    int p;
                    logic [7:0] bb;
                    p  = c * m_lanes + j;
                    bb = fbyte(m_addr + 32'(p / 8));
                    if (m_lanes == 1) v[1] = bb[7 - (p % 8)];
                    else              v[m_lanes - 1 - j] = bb[7 - (p % 8)];
                end
                io_in = v;
                @(posedge sclk);
            end
        end
    end

    task automatic arm(input logic [31:0] w);
        @(negedge clk) mode_reset = 1'b1;
        @(negedge clk) mode_reset = 1'b0; tmpl_wr = 1'b1; tmpl_wdata = w;
        @(negedge clk) tmpl_wr = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                           output logic [31:0] got, output bit ok);
        int n;
        @(negedge clk) bus_addr = a; bus_size = sz; bus_valid = 1'b1;
        n = 0;
        while (!bus_ready && n < 3000) begin
            @(negedge clk); n++;
        end
        ok = bus_ready; got = bus_rdata; bus_valid = 1'b0;
    endtask

    task automatic read_and_check(input logic [7:0] op, input logic [31:0] a,
                                  input logic [1:0] sz, input string tag);
        logic [31:0] got, exp, msk, ma;
        bit ok;
        int exp_clk;
        m_nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        msk  = (m_ab == 4) ? 32'hFFFF_FFFF : 32'((64'd1 << (8 * m_ab)) - 64'd1);
        ma   = a & msk;
        exp  = '0;
        for (int k = 0; k < m_nb; k++) exp[8*k +: 8] = fbyte(ma + 32'(k));
        exp_clk = 8 + 8 * m_ab + 8 * m_gap + (m_nb * 8) / m_lanes;
        do_read(a, sz, got, ok);
        chk(ok, {tag, " R7 ready"}, 32'(ok), 32'd1);
        chk(got == exp, {tag, " R5 R6 rdata"}, got, exp);
        chk(m_op == op, {tag, " R3 opcode"}, 32'(m_op), 32'(op));
        chk(m_addr == ma, {tag, " R3 address"}, m_addr, ma);
        chk(clk_cnt == exp_clk, {tag, " R4 R6 clocks"}, 32'(clk_cnt), 32'(exp_clk));
        chk(!m_dummy_oe, {tag, " R4 dummy oe"}, 32'(m_dummy_oe), 32'd0);
        @(negedge clk);
        chk(!bus_ready && cs_n, {tag, " R7 pulse"}, {30'd0, bus_ready, cs_n}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!mem_active && !cmd_err && !bus_ready && !sclk && cs_n, "R1 reset",
            {27'd0, mem_active, cmd_err, bus_ready, sclk, cs_n}, 32'd1);

        // R9: command write while off raises no error
        @(negedge clk) cmd_wr = 1'b1;
        @(negedge clk) cmd_wr = 1'b0;
        @(negedge clk);
        chk(!cmd_err, "R9 no error when off", 32'(cmd_err), 32'd0);

        // R2: refused templates
        arm(mk(8'h0B, 3'd1, 2'd0, 3'd0));
        chk(!mem_active, "R2 frame code 1", 32'(mem_active), 32'd0);
        arm(mk(8'h0B, 3'd6, 2'd0, 3'd0));
        chk(!mem_active, "R2 frame code 6", 32'(mem_active), 32'd0);
        arm(mk(8'h0B, 3'd4, 2'd2, 3'd0));
        chk(!mem_active, "R2 lane format 2", 32'(mem_active), 32'd0);

        // Sweep: address length x dummy count x lane mode x width
        for (int ab = 1; ab <= 4; ab++) begin
            for (int gap = 0; gap <= 2; gap++) begin
                for (int md = 0; md < 3; md++) begin
                    logic [7:0] op;
                    op = 8'(8'h10 + ab * 16 + gap * 4 + md);
                    lane_quad = (md == 2);
                    m_ab = ab; m_gap = gap;
                    m_lanes = (md == 0) ? 1 : (md == 1) ? 2 : 4;
                    arm(mk(op, 3'(ab + 1), 2'(md != 0), 3'(gap)));
                    chk(mem_active, "R1 R2 arm", 32'(mem_active), 32'd1);
                    for (int sz = 0; sz < 3; sz++) begin
                        logic [31:0] a;
                        a = 32'hA1B2C3D4 + 32'(ab * 32'h0101_0111 + gap * 32'h0030_0507 + md * 32'h0700_0093 + sz * 13);
                        read_and_check(op, a, 2'(sz), "sweep");
                    end
                end
            end
        end

        // R9 and R10 while active
        lane_quad = 1'b0; m_ab = 3; m_gap = 1; m_lanes = 1;
        arm(mk(8'h6B, 3'd4, 2'd0, 3'd1));
        @(negedge clk) cmd_wr = 1'b1;
        @(negedge clk) cmd_wr = 1'b0;
        @(negedge clk);
        chk(cmd_err, "R9 error while active", 32'(cmd_err), 32'd1);
        @(negedge clk) tmpl_wr = 1'b1; tmpl_wdata = mk(8'hEB, 3'd5, 2'd1, 3'd0);
        @(negedge clk) tmpl_wr = 1'b0;
        read_and_check(8'h6B, 32'h1234_5678, 2'd2, "R10 ignored template");
        read_and_check(8'h6B, 32'h00FF_0102, 2'd3, "R10 size 3");

        // R8: leave memory mode
        @(negedge clk) mode_reset = 1'b1;
        @(negedge clk) mode_reset = 1'b0;
        chk(!mem_active, "R8 mode off", 32'(mem_active), 32'd0);
        chk(cmd_err, "R9 sticky after mode reset", 32'(cmd_err), 32'd1);
        begin
            bit seen;
            seen = 1'b0;
            bus_valid = 1'b1; bus_addr = 32'h55; bus_size = 2'd0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (!cs_n || bus_ready) seen = 1'b1;
            end
            bus_valid = 1'b0;
            chk(!seen, "R8 held read ignored", 32'(seen), 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule